// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

This block fetches one instruction at a given program counter when the instruction stream mixes 16-bit compressed and 32-bit base encodings. A fetch begins with a one-cycle start pulse that carries the PC. The PC is checked for alignment first. After that, memory is reached in 16-bit granules. Each granule gets its own address translation request and then its own 16-bit memory read at the physical address that translation returned.

The lower granule decides the length of the instruction. If its two low bits are anything other than `2'b11`, the fetch ends with that single granule as a compressed instruction. Otherwise the granule at PC+2 is translated and read, and the two granules are joined into a 32-bit word. A fault on either granule ends the fetch with an error. The error carries a cause code and the virtual address of the granule that failed.

The result comes back as a one-cycle done pulse with a kind code, the instruction bits, a cause and an address. A core front end places this block between its PC logic and its decoder. The block has no cache and no prefetch buffer.

Top module: `insn_fetch_unit`

## Requirements
- R1: A start with PC bit 0 set ends at once with kind 2'b10, cause CAUSE_MISALIGN (default 0) and address equal to the PC. No translation or memory request is made.
- R2: When `rvcEnable` is low at start, a PC with bit 1 set fails the same way as R1. When `rvcEnable` is high, such a PC is fetched normally.
- R3: The lower granule is translated first at virtual address PC. It is then read at the physical address that the translator returned.
- R4: A lower granule whose bits [1:0] are not 2'b11 completes the fetch as kind 2'b01, with `doneInstr` = {16'h0, granule}. Exactly one translation and one memory read are made.
- R5: A lower granule with bits [1:0] equal to 2'b11 causes a second translation at PC+2, followed by a read at its physical address.
- R6: A base fetch completes as kind 2'b00, with the upper granule in `doneInstr[31:16]` and the lower granule in `doneInstr[15:0]`.
- R7: A translation fault ends the fetch as kind 2'b10 with the translator's own cause code. The address is PC for the lower granule and PC+2 for the upper granule.
- R8: A memory read error ends the fetch as kind 2'b10 with cause CAUSE_ACCESS (default 1). The address is PC for the lower granule and PC+2 for the upper granule.
- R9: Each fetch gives exactly one single-cycle `doneValid` pulse. A successful fetch reports cause 0 and address PC. `busy` is high from the cycle after an accepted start until the result is given.
- R10: A start pulse that arrives while a fetch is in progress is ignored. It does not change the result, and it does not cause a second result.
- R11: Translation and memory requests stay asserted with a stable address until their response is valid, for any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a fetch (sampled only when idle) |
| startPc | input | XLEN | PC of the fetch |
| rvcEnable | input | 1 | Compressed support enable, sampled at start |
| xlReqValid | output | 1 | Translation request |
| xlReqVaddr | output | XLEN | Virtual address of the granule |
| xlRspValid | input | 1 | Translation response valid |
| xlRspFault | input | 1 | Translation failed |
| xlRspCause | input | CAUSE_W | Cause code of a translation failure |
| xlRspPaddr | input | PADDR_W | Physical address returned |
| memReqValid | output | 1 | 16-bit read request |
| memReqAddr | output | PADDR_W | Physical read address |
| memRspValid | input | 1 | Read response valid |
| memRspErr | input | 1 | Read access fault |
| memRspData | input | 16 | Read granule |
| doneValid | output | 1 | One-cycle result pulse |
| doneKind | output | 2 | 00 base, 01 compressed, 10 error |
| doneInstr | output | 32 | Instruction bits (0 on error) |
| doneCause | output | CAUSE_W | Error cause (0 on success) |
| doneAddr | output | XLEN | Fault address, or the PC on success |
| busy | output | 1 | Fetch in progress |

## Verification
The bench targets PCs that are odd, PCs with bit 1 set with compressed support on and off, and a base instruction that straddles a 4-byte boundary. A design that checks only bit 0, or that always demands 4-byte alignment, gives the wrong verdict in the bit-1 cases. Faults are placed on each granule in turn. A design that reports PC for an upper-granule fault, or that replaces the translator's cause with a fixed code, gives the wrong address or cause. Counting requests shows whether a compressed instruction wrongly triggers a second read. The response latency is varied, and a stray start is sent in the middle of a fetch, to expose a design that drops its request early or restarts.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  typedef enum logic [1:0] {
    KIND_BASE = 2'b00,
    KIND_RVC  = 2'b01,
    KIND_ERR  = 2'b10
  } fetchKindT;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_ALIGN  = 2'b01,
    ERR_XLAT   = 2'b10,
    ERR_ACCESS = 2'b11
  } errSrcT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLAT_LO,
    ST_MEM_LO,
    ST_XLAT_HI,
    ST_MEM_HI
  } fetchStateT;

  typedef struct packed {
    logic      ldPc;
    logic      ldPaddr;
    logic      ldLo;
    logic      useHi;
    logic      finish;
    fetchKindT kind;
    errSrcT    errSrc;
  } ctrlStrobeT;

endpackage

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       misaligned,
  input  logic       loCompressed,
  input  logic       xlRspValid,
  input  logic       xlRspFault,
  input  logic       memRspValid,
  input  logic       memRspErr,
  output logic       xlReqValid,
  output logic       memReqValid,
  output logic       busy,
  output ctrlStrobeT strobe
);

  fetchStateT stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '{ldPc: 1'b0, ldPaddr: 1'b0, ldLo: 1'b0, useHi: 1'b0,
               finish: 1'b0, kind: KIND_BASE, errSrc: ERR_NONE};
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          if (misaligned) begin
            strobe.finish = 1'b1;
            strobe.kind   = KIND_ERR;
            strobe.errSrc = ERR_ALIGN;
          end else begin
            strobe.ldPc = 1'b1;
            stateD      = ST_XLAT_LO;
          end
        end
      end
      ST_XLAT_LO, ST_XLAT_HI: begin
        strobe.useHi = (stateQ == ST_XLAT_HI);
        if (xlRspValid) begin
          if (xlRspFault) begin
            strobe.finish = 1'b1;
            strobe.kind   = KIND_ERR;
            strobe.errSrc = ERR_XLAT;
            stateD        = ST_IDLE;
          end else begin
            strobe.ldPaddr = 1'b1;
            stateD = (stateQ == ST_XLAT_HI) ? ST_MEM_HI : ST_MEM_LO;
          end
        end
      end
      ST_MEM_LO: begin
        if (memRspValid) begin
          if (memRspErr) begin
            strobe.finish = 1'b1;
            strobe.kind   = KIND_ERR;
            strobe.errSrc = ERR_ACCESS;
            stateD        = ST_IDLE;
          end else if (loCompressed) begin
            strobe.finish = 1'b1;
            strobe.kind   = KIND_RVC;
            stateD        = ST_IDLE;
          end else begin
            strobe.ldLo = 1'b1;
            stateD      = ST_XLAT_HI;
          end
        end
      end
      ST_MEM_HI: begin
        strobe.useHi = 1'b1;
        if (memRspValid) begin
          strobe.finish = 1'b1;
          strobe.kind   = memRspErr ? KIND_ERR : KIND_BASE;
          strobe.errSrc = memRspErr ? ERR_ACCESS : ERR_NONE;
          stateD        = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign xlReqValid  = (stateQ == ST_XLAT_LO) || (stateQ == ST_XLAT_HI);
  assign memReqValid = (stateQ == ST_MEM_LO) || (stateQ == ST_MEM_HI);
  assign busy        = (stateQ != ST_IDLE);

  // Every read is preceded by a successful translation of its granule.
  assert_read_after_xlat_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(xlReqValid && xlRspValid && !xlRspFault));

  // A second translation only ever follows a non-compressed lower granule.
  assert_hi_needs_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_XLAT_HI && $past(stateQ) == ST_MEM_LO)
      |-> $past(memRspValid && !memRspErr && !loCompressed));

  // While waiting with no response, nothing (including a new start) moves the FSM.
  assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xlRspValid && !memRspValid) |=> $stable(stateQ));

  // Requests are held until answered.
  assert_xl_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (xlReqValid && !xlRspValid) |=> xlReqValid);

  assert_mem_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> memReqValid);

endmodule

// File: rtl/ifu_datapath.sv
module ifu_datapath
  import ifu_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter int PADDR_W        = 32,
  parameter int CAUSE_W        = 5,
  parameter int CAUSE_MISALIGN = 0,
  parameter int CAUSE_ACCESS   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic [XLEN-1:0]    startPc,
  input  logic               rvcEnable,
  input  logic [CAUSE_W-1:0] xlRspCause,
  input  logic [PADDR_W-1:0] xlRspPaddr,
  input  logic [15:0]        memRspData,
  output logic               misaligned,
  output logic               loCompressed,
  output logic [XLEN-1:0]    xlReqVaddr,
  output logic [PADDR_W-1:0] memReqAddr,
  output logic               doneValid,
  output logic [1:0]         doneKind,
  output logic [31:0]        doneInstr,
  output logic [CAUSE_W-1:0] doneCause,
  output logic [XLEN-1:0]    doneAddr
);

  localparam logic [XLEN-1:0]    GRANULE_BYTES = XLEN'(2);
  localparam logic [CAUSE_W-1:0] MISALIGN_CODE = CAUSE_W'(CAUSE_MISALIGN);
  localparam logic [CAUSE_W-1:0] ACCESS_CODE   = CAUSE_W'(CAUSE_ACCESS);

  logic [XLEN-1:0]    pcQ;
  logic [PADDR_W-1:0] paddrQ;
  logic [15:0]        loQ;
  logic [XLEN-1:0]    granuleVaddr;
  logic [CAUSE_W-1:0] causeSel;
  logic [31:0]        instrSel;
  logic [XLEN-1:0]    addrSel;

  assign misaligned   = startPc[0] | (startPc[1] & ~rvcEnable);
  assign loCompressed = (memRspData[1:0] != 2'b11);
  assign granuleVaddr = strobe.useHi ? (pcQ + GRANULE_BYTES) : pcQ;
  assign xlReqVaddr   = granuleVaddr;
  assign memReqAddr   = paddrQ;

  always_comb begin
    unique case (strobe.errSrc)
      ERR_ALIGN:  causeSel = MISALIGN_CODE;
      ERR_XLAT:   causeSel = xlRspCause;
      ERR_ACCESS: causeSel = ACCESS_CODE;
      default:    causeSel = '0;
    endcase
    unique case (strobe.kind)
      KIND_BASE: instrSel = {memRspData, loQ};
      KIND_RVC:  instrSel = {16'h0000, memRspData};
      default:   instrSel = '0;
    endcase
    if (strobe.errSrc == ERR_ALIGN)    addrSel = startPc;
    else if (strobe.kind == KIND_ERR)  addrSel = granuleVaddr;
    else                               addrSel = pcQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ       <= '0;
      paddrQ    <= '0;
      loQ       <= '0;
      doneValid <= 1'b0;
      doneKind  <= KIND_BASE;
      doneInstr <= '0;
      doneCause <= '0;
      doneAddr  <= '0;
    end else begin
      if (strobe.ldPc)    pcQ    <= startPc;
      if (strobe.ldPaddr) paddrQ <= xlRspPaddr;
      if (strobe.ldLo)    loQ    <= memRspData;
      doneValid <= strobe.finish;
      if (strobe.finish) begin
        doneKind  <= strobe.kind;
        doneInstr <= instrSel;
        doneCause <= causeSel;
        doneAddr  <= addrSel;
      end
    end
  end

  // Result encodings stay within the three defined kinds.
  assert_kind_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneKind != 2'b11));

  // A compressed result never carries a base-length marker.
  assert_rvc_marker_R4: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneKind == KIND_RVC) |-> (doneInstr[1:0] != 2'b11 && doneInstr[31:16] == 16'h0));

  // A base result always carries the base-length marker in its low half.
  assert_base_marker_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneKind == KIND_BASE) |-> (doneInstr[1:0] == 2'b11));

  // The second translation targets the granule two bytes above the first.
  assert_hi_vaddr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.useHi && $past(strobe.ldLo)) |-> (xlReqVaddr == $past(xlReqVaddr) + GRANULE_BYTES));

endmodule

// File: rtl/insn_fetch_unit.sv
module insn_fetch_unit
  import ifu_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter int PADDR_W        = 32,
  parameter int CAUSE_W        = 5,
  parameter int CAUSE_MISALIGN = 0,
  parameter int CAUSE_ACCESS   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [XLEN-1:0]    startPc,
  input  logic               rvcEnable,
  output logic               xlReqValid,
  output logic [XLEN-1:0]    xlReqVaddr,
  input  logic               xlRspValid,
  input  logic               xlRspFault,
  input  logic [CAUSE_W-1:0] xlRspCause,
  input  logic [PADDR_W-1:0] xlRspPaddr,
  output logic               memReqValid,
  output logic [PADDR_W-1:0] memReqAddr,
  input  logic               memRspValid,
  input  logic               memRspErr,
  input  logic [15:0]        memRspData,
  output logic               doneValid,
  output logic [1:0]         doneKind,
  output logic [31:0]        doneInstr,
  output logic [CAUSE_W-1:0] doneCause,
  output logic [XLEN-1:0]    doneAddr,
  output logic               busy
);

  ctrlStrobeT strobe;
  logic       misaligned;
  logic       loCompressed;

  ifu_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .misaligned   (misaligned),
    .loCompressed (loCompressed),
    .xlRspValid   (xlRspValid),
    .xlRspFault   (xlRspFault),
    .memRspValid  (memRspValid),
    .memRspErr    (memRspErr),
    .xlReqValid   (xlReqValid),
    .memReqValid  (memReqValid),
    .busy         (busy),
    .strobe       (strobe)
  );

  ifu_datapath #(
    .XLEN           (XLEN),
    .PADDR_W        (PADDR_W),
    .CAUSE_W        (CAUSE_W),
    .CAUSE_MISALIGN (CAUSE_MISALIGN),
    .CAUSE_ACCESS   (CAUSE_ACCESS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .startPc      (startPc),
    .rvcEnable    (rvcEnable),
    .xlRspCause   (xlRspCause),
    .xlRspPaddr   (xlRspPaddr),
    .memRspData   (memRspData),
    .misaligned   (misaligned),
    .loCompressed (loCompressed),
    .xlReqVaddr   (xlReqVaddr),
    .memReqAddr   (memReqAddr),
    .doneValid    (doneValid),
    .doneKind     (doneKind),
    .doneInstr    (doneInstr),
    .doneCause    (doneCause),
    .doneAddr     (doneAddr)
  );

  // Addresses stay stable while a request waits for its response.
  assert_xl_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (xlReqValid && !xlRspValid) |=> $stable(xlReqVaddr));

  assert_mem_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> $stable(memReqAddr));

  // Requests never overlap: one granule operation at a time.
  assert_one_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones({xlReqValid, memReqValid}) <= 1);

endmodule

// File: tb/tb_insn_fetch_unit.sv
module tb_insn_fetch_unit;

  localparam int XLEN = 32;
  localparam int PAW  = 32;
  localparam int CW   = 5;
  localparam logic [31:0] PA_OFFS  = 32'h0000_8000;
  localparam logic [CW-1:0] XL_CAUSE = 5'd13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic            startReq = 1'b0;
  logic [XLEN-1:0] startPc = '0;
  logic            rvcEnable = 1'b1;
  logic            xlReqValid, memReqValid, doneValid, busy;
  logic [XLEN-1:0] xlReqVaddr, doneAddr;
  logic            xlRspValid = 1'b0, xlRspFault = 1'b0;
  logic [CW-1:0]   xlRspCause = '0;
  logic [PAW-1:0]  xlRspPaddr = '0;
  logic [PAW-1:0]  memReqAddr;
  logic            memRspValid = 1'b0, memRspErr = 1'b0;
  logic [15:0]     memRspData = '0;
  logic [1:0]      doneKind;
  logic [31:0]     doneInstr;
  logic [CW-1:0]   doneCause;

  insn_fetch_unit dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startPc(startPc), .rvcEnable(rvcEnable),
    .xlReqValid(xlReqValid), .xlReqVaddr(xlReqVaddr), .xlRspValid(xlRspValid),
    .xlRspFault(xlRspFault), .xlRspCause(xlRspCause), .xlRspPaddr(xlRspPaddr),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspErr(memRspErr), .memRspData(memRspData), .doneValid(doneValid),
    .doneKind(doneKind), .doneInstr(doneInstr), .doneCause(doneCause),
    .doneAddr(doneAddr), .busy(busy)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory/translator model state
  logic [31:0] mPc = '0;
  logic [15:0] mLo = '0, mHi = '0;
  logic [1:0]  mXlFault = '0, mMemErr = '0;
  int          mLat = 0;
  int          xlCnt = 0, memCnt = 0;
  int          xlN = 0, memN = 0;
  logic [31:0] xlA0 = '0, xlA1 = '0, memA0 = '0, memA1 = '0;

  always @(negedge clk) begin
    if (xlReqValid) begin
      if (xlCnt < mLat) begin
        xlCnt++;
        xlRspValid = 1'b0;
      end else if (!xlRspValid) begin
        xlRspValid = 1'b1;
        xlRspPaddr = xlReqVaddr + PA_OFFS;
        xlRspFault = (mXlFault == 2'd1 && xlReqVaddr == mPc) ||
                     (mXlFault == 2'd2 && xlReqVaddr == mPc + 32'd2);
        xlRspCause = xlRspFault ? XL_CAUSE : '0;
        if (xlN == 0) xlA0 = xlReqVaddr; else xlA1 = xlReqVaddr;
        xlN++;
      end
    end else begin
      xlCnt = 0;
      xlRspValid = 1'b0;
      xlRspFault = 1'b0;
    end
    if (memReqValid) begin
      if (memCnt < mLat) begin
        memCnt++;
        memRspValid = 1'b0;
      end else if (!memRspValid) begin
        memRspValid = 1'b1;
        memRspData = (memReqAddr == mPc + PA_OFFS) ? mLo :
                     (memReqAddr == mPc + 32'd2 + PA_OFFS) ? mHi : 16'hDEAD;
        memRspErr = (mMemErr == 2'd1 && memReqAddr == mPc + PA_OFFS) ||
                    (mMemErr == 2'd2 && memReqAddr == mPc + 32'd2 + PA_OFFS);
        if (memN == 0) memA0 = memReqAddr; else memA1 = memReqAddr;
        memN++;
      end
    end else begin
      memCnt = 0;
      memRspValid = 1'b0;
      memRspErr = 1'b0;
    end
  end

  typedef struct packed {
    logic [31:0] pc;
    logic        rvc;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [1:0]  xlf;
    logic [1:0]  mef;
    logic [1:0]  lat;
    logic [1:0]  eKind;
    logic [31:0] eInstr;
    logic [4:0]  eCause;
    logic [31:0] eAddr;
    logic [1:0]  eXl;
    logic [1:0]  eMem;
  } vecT;

  localparam int NV = 12;
  localparam vecT VECS [NV] = '{
    // R4: compressed at aligned PC
    '{32'h100, 1'b1, 16'h4501, 16'h0000, 2'd0, 2'd0, 2'd0, 2'b01, 32'h0000_4501, 5'd0,  32'h100, 2'd1, 2'd1},
    // R5/R6: base instruction
    '{32'h104, 1'b1, 16'h0513, 16'h00A5, 2'd0, 2'd0, 2'd0, 2'b00, 32'h00A5_0513, 5'd0,  32'h104, 2'd2, 2'd2},
    // R2/R4: bit 1 set with compressed enabled, slow responses
    '{32'h202, 1'b1, 16'h8082, 16'h0000, 2'd0, 2'd0, 2'd2, 2'b01, 32'h0000_8082, 5'd0,  32'h202, 2'd1, 2'd1},
    // R6: base straddling a 4-byte boundary
    '{32'h202, 1'b1, 16'h1117, 16'h0000, 2'd0, 2'd0, 2'd1, 2'b00, 32'h0000_1117, 5'd0,  32'h202, 2'd2, 2'd2},
    // R1: odd PC
    '{32'h301, 1'b1, 16'h0000, 16'h0000, 2'd0, 2'd0, 2'd0, 2'b10, 32'h0,         5'd0,  32'h301, 2'd0, 2'd0},
    // R2: bit 1 set, compressed disabled
    '{32'h302, 1'b0, 16'h0000, 16'h0000, 2'd0, 2'd0, 2'd0, 2'b10, 32'h0,         5'd0,  32'h302, 2'd0, 2'd0},
    // R2: aligned PC, compressed disabled, fetched normally
    '{32'h300, 1'b0, 16'h0093, 16'h0010, 2'd0, 2'd0, 2'd0, 2'b00, 32'h0010_0093, 5'd0,  32'h300, 2'd2, 2'd2},
    // R7: translation fault on lower granule
    '{32'h400, 1'b1, 16'h0003, 16'h0000, 2'd1, 2'd0, 2'd0, 2'b10, 32'h0,         5'd13, 32'h400, 2'd1, 2'd0},
    // R7: translation fault on upper granule
    '{32'h400, 1'b1, 16'h0003, 16'h0000, 2'd2, 2'd0, 2'd1, 2'b10, 32'h0,         5'd13, 32'h402, 2'd2, 2'd1},
    // R8: access fault on lower granule
    '{32'h500, 1'b1, 16'h2783, 16'h0000, 2'd0, 2'd1, 2'd0, 2'b10, 32'h0,         5'd1,  32'h500, 2'd1, 2'd1},
    // R8: access fault on upper granule
    '{32'h500, 1'b1, 16'h2783, 16'h0000, 2'd0, 2'd2, 2'd3, 2'b10, 32'h0,         5'd1,  32'h502, 2'd2, 2'd2},
    // R6/R11: all-ones base with long waits
    '{32'h600, 1'b1, 16'hFFFF, 16'hFFFF, 2'd0, 2'd0, 2'd3, 2'b00, 32'hFFFF_FFFF, 5'd0,  32'h600, 2'd2, 2'd2}
  };

  bit timedOut = 0;

  task automatic setupModel(input vecT v);
    mPc = v.pc; mLo = v.lo; mHi = v.hi;
    mXlFault = v.xlf; mMemErr = v.mef; mLat = int'(v.lat);
    xlN = 0; memN = 0;
  endtask

  // Drive a start pulse and wait for the done pulse; leaves the bench at the done negedge.
  task automatic startAndWait(input logic [31:0] pc, input logic rvc, output bit got);
    @(negedge clk);
    startPc = pc; rvcEnable = rvc; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    got = 0;
    for (int k = 0; k < 200; k++) begin
      if (doneValid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    timedOut = 1;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", "reset doneValid", {31'b0, doneValid}, 32'd0);
    check("R9", "reset busy", {31'b0, busy}, 32'd0);
    check("R11", "reset requests", {30'b0, xlReqValid, memReqValid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vecT v;
      bit got;
      v = VECS[i];
      setupModel(v);
      startAndWait(v.pc, v.rvc, got);
      check("R9", $sformatf("vec%0d done seen", i), {31'b0, got}, 32'd1);
      check(v.eKind == 2'b10 ? (v.eCause == 5'd1 ? "R8" : (v.eCause == 5'd13 ? "R7" : "R1")) : (v.eKind == 2'b01 ? "R4" : "R6"),
            $sformatf("vec%0d kind", i), {30'b0, doneKind}, {30'b0, v.eKind});
      check("R6", $sformatf("vec%0d instr", i), doneInstr, v.eInstr);
      check("R7", $sformatf("vec%0d cause", i), {27'b0, doneCause}, {27'b0, v.eCause});
      check("R7", $sformatf("vec%0d addr", i), doneAddr, v.eAddr);
      check("R5", $sformatf("vec%0d translations", i), xlN, {30'b0, v.eXl});
      check("R4", $sformatf("vec%0d reads", i), memN, {30'b0, v.eMem});
      if (v.eXl >= 2'd1) check("R3", $sformatf("vec%0d lo vaddr", i), xlA0, v.pc);
      if (v.eXl == 2'd2) check("R5", $sformatf("vec%0d hi vaddr", i), xlA1, v.pc + 32'd2);
      if (v.eMem >= 2'd1) check("R3", $sformatf("vec%0d lo paddr", i), memA0, v.pc + PA_OFFS);
      if (v.eMem == 2'd2) check("R5", $sformatf("vec%0d hi paddr", i), memA1, v.pc + 32'd2 + PA_OFFS);
      @(negedge clk);
      check("R9", $sformatf("vec%0d done one cycle", i), {31'b0, doneValid}, 32'd0);
      check("R9", $sformatf("vec%0d idle after", i), {31'b0, busy}, 32'd0);
    end

    // R9: busy rises the cycle after an accepted start
    begin
      vecT v;
      v = VECS[11];
      setupModel(v);
      @(negedge clk);
      startPc = v.pc; rvcEnable = 1'b1; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      check("R9", "busy after start", {31'b0, busy}, 32'd1);
      for (int k = 0; k < 200 && !doneValid; k++) @(negedge clk);
      @(negedge clk);
    end

    // R10: start pulses during a fetch are ignored
    begin
      int dones;
      mPc = 32'h700; mLo = 16'h4501; mHi = 16'h0; mXlFault = 0; mMemErr = 0; mLat = 3;
      xlN = 0; memN = 0;
      @(negedge clk);
      startPc = 32'h700; rvcEnable = 1'b1; startReq = 1'b1;
      @(negedge clk);
      startPc = 32'h801;
      @(negedge clk);
      @(negedge clk);
      startReq = 1'b0;
      dones = 0;
      for (int k = 0; k < 30; k++) begin
        if (doneValid) begin
          dones++;
          check("R10", "result addr", doneAddr, 32'h700);
          check("R10", "result kind", {30'b0, doneKind}, 32'd1);
        end
        @(negedge clk);
      end
      check("R10", "single result", dones, 32'd1);
      check("R10", "single translation", xlN, 32'd1);
      check("R10", "idle at end", {31'b0, busy}, 32'd0);
    end

    if (!timedOut) begin
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule